// File: doc/BRIEF.md
# Low-Power State Controller

This block decides which clocks of a small 8-bit controller core are running. Software writes a control strobe that carries two request bits. One bit asks for a light sleep, in which only the processor clock is held and the peripherals keep running. The other asks for a deep sleep, in which the oscillator enable is dropped and every clock stops. The processor, the peripherals, the RAM and the oscillator itself are outside the block. They are seen only through the three clock or oscillator enables, a wake strobe and a flag that tells the RAM to keep its contents.

The two sleep states are left in different ways. Light sleep ends on any enabled interrupt. The processor clock then restarts on the next machine-cycle boundary, where a machine cycle is 12 oscillator clocks, and a one-clock wake strobe goes to the interrupt logic. Deep sleep ignores interrupts and ends only through a qualified hardware reset.

The raw reset pin counts as a reset only after it has been sampled high on 24 consecutive clocks, which is two machine cycles. A single low sample restarts the count. The qualified reset puts the block back into the running state. The retain flag stays raised while that reset is active, so the RAM contents survive it.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After the block reset, the state is running: `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, and `wake_pulse`, `sys_reset` and `ram_retain` are 0.
- R2: In the running state, a write with `req_idle`=1 and `req_pd`=0 drops `cpu_clk_en` one clock later. `per_clk_en` and `osc_en` stay at 1.
- R3: In the running state, a write with `req_pd`=1 drops all three enables one clock later. This holds even when `req_idle` is also 1, because the deep-sleep bit wins.
- R4: In light sleep, a sampled `irq_pend` restarts `cpu_clk_en` on the next machine-cycle boundary, between 1 and 12 clocks after the clock that sampled it. `wake_pulse` is 1 for exactly the first clock in which `cpu_clk_en` is 1 again.
- R5: `irq_pend` has no effect in deep sleep: all enables stay at 0. It also has no effect in the running state: `wake_pulse` stays at 0.
- R6: `sys_reset` becomes 1 after the 24th consecutive high sample of `rst_pin`. It stays 1 while the pin is held high. A low sample clears the count, so 23 highs followed by a low never raise it.
- R7: While `sys_reset` is 1, the next clock returns the block to the running state, whether it was in light sleep, waking or deep sleep.
- R8: In deep sleep, `osc_en` follows `rst_pin` in the same cycle, so the oscillator restarts while reset is held and the reset can qualify.
- R9: In light sleep, control writes are ignored. An `irq_pend` arriving in the same clock as a deep-sleep write resolves to the wake-up: `per_clk_en` stays at 1.
- R10: `ram_retain` is 1 in deep sleep and while `sys_reset` is 1. It is 0 in the running state and in light sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on oscillator-domain clock |
| rst | input | 1 | Synchronous active-high block reset |
| rst_pin | input | 1 | Raw hardware reset pin, active high |
| req_wr | input | 1 | Control-write strobe from software |
| req_idle | input | 1 | Light-sleep request bit of the write |
| req_pd | input | 1 | Deep-sleep request bit of the write |
| irq_pend | input | 1 | Any enabled interrupt request pending |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral/RAM/timer clock enable |
| osc_en | output | 1 | Oscillator enable |
| wake_pulse | output | 1 | One-clock wake strobe to interrupt logic |
| sys_reset | output | 1 | Qualified reset to the special registers |
| ram_retain | output | 1 | RAM contents must be retained |

## Verification
State changes caused by a write or an interrupt appear one clock after the edge that sampled them. `sys_reset` rises after the 24th high sample, and the return to the running state follows one clock later. `osc_en` follows `rst_pin` in deep sleep without any delay. The wake from light sleep lands anywhere from 1 to 12 clocks after the sampling edge, depending on the phase of the machine cycle. The bench therefore drives every input on the falling edge and reads results on the next falling edge. It counts clocks to bound that window and checks that the wake strobe coincides with the first clock of the restarted processor clock.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_WAKE = 2'd2,
        PM_DOWN = 2'd3
    } pm_state_e;

    typedef struct packed {
        logic wr;
        logic idle;
        logic pd;
    } pm_req_t;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
    } pm_gate_t;

    // Clock enables per state; the raw reset pin restarts the oscillator in deep sleep
    function automatic pm_gate_t gates_for(pm_state_e s, logic pin_hi);
        pm_gate_t g;
        g.cpu = (s == PM_RUN);
        g.per = (s != PM_DOWN);
        g.osc = (s != PM_DOWN) || pin_hi;
        return g;
    endfunction

endpackage

// File: rtl/pwr_mcycle.sv
module pwr_mcycle #(
    parameter int MC_LEN = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic realign,
    output logic mc_last,
    output logic mc_first
);
    localparam int PW = (MC_LEN > 1) ? $clog2(MC_LEN) : 1;

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || realign) begin
            phase <= '0;
        end else if (phase == PW'(MC_LEN - 1)) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign mc_last  = (phase == PW'(MC_LEN - 1));
    assign mc_first = (phase == '0);

    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        phase <= PW'(MC_LEN - 1));

endmodule

// File: rtl/pwr_rst_qual.sv
module pwr_rst_qual #(
    parameter int QUAL = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_pin,
    output logic qualified
);
    localparam int CW = $clog2(QUAL + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !rst_pin) begin
            cnt <= '0;
        end else if (cnt != CW'(QUAL)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign qualified = (cnt == CW'(QUAL));

    // R6
    low_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !rst_pin |=> !qualified);

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(QUAL));

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pm_req_t   req,
    input  logic      irq,
    input  logic      sys_rst,
    input  logic      mc_last,
    output pm_state_e state,
    output logic      wake
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PM_RUN;
            wake  <= 1'b0;
        end else begin
            wake <= 1'b0;
            if (sys_rst) begin
                state <= PM_RUN;
            end else begin
                unique case (state)
                    PM_RUN: begin
                        if (req.wr && req.pd) begin
                            state <= PM_DOWN;
                        end else if (req.wr && req.idle) begin
                            state <= PM_IDLE;
                        end
                    end
                    PM_IDLE: begin
                        if (irq) begin
                            state <= PM_WAKE;
                        end
                    end
                    PM_WAKE: begin
                        if (mc_last) begin
                            state <= PM_RUN;
                            wake  <= 1'b1;
                        end
                    end
                    PM_DOWN: state <= PM_DOWN;
                    default: state <= PM_RUN;
                endcase
            end
        end
    end

    // R5
    pd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PM_DOWN && !sys_rst) |=> (state == PM_DOWN));

    // R7
    rst_exit_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst |=> (state == PM_RUN));

    // R9
    idle_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PM_IDLE && irq && !sys_rst) |=> (state == PM_WAKE));

endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
    import pwr_pkg::*;
#(
    parameter int MC_LEN   = 12,
    parameter int RST_MCYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_pin,
    input  logic req_wr,
    input  logic req_idle,
    input  logic req_pd,
    input  logic irq_pend,
    output logic cpu_clk_en,
    output logic per_clk_en,
    output logic osc_en,
    output logic wake_pulse,
    output logic sys_reset,
    output logic ram_retain
);
    localparam int QUAL = MC_LEN * RST_MCYC;

    pm_req_t   req;
    pm_state_e state;
    pm_gate_t  gates;
    logic      mc_last;
    logic      mc_first;
    logic      qual;

    assign req = '{wr: req_wr, idle: req_idle, pd: req_pd};

    pwr_rst_qual #(.QUAL(QUAL)) u_qual (
        .clk       (clk),
        .rst       (rst),
        .rst_pin   (rst_pin),
        .qualified (qual)
    );

    pwr_mcycle #(.MC_LEN(MC_LEN)) u_mcyc (
        .clk      (clk),
        .rst      (rst),
        .realign  (qual),
        .mc_last  (mc_last),
        .mc_first (mc_first)
    );

    pwr_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .irq     (irq_pend),
        .sys_rst (qual),
        .mc_last (mc_last),
        .state   (state),
        .wake    (wake_pulse)
    );

    assign gates      = gates_for(state, rst_pin);
    assign cpu_clk_en = gates.cpu;
    assign per_clk_en = gates.per;
    assign osc_en     = gates.osc;
    assign sys_reset  = qual;
    assign ram_retain = (state == PM_DOWN) || qual;

    // R4
    wake_align_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> (mc_first && cpu_clk_en));

    // R10
    retain_chk: assert property (@(posedge clk) disable iff (rst)
        !per_clk_en |-> ram_retain);

    // R2
    gate_order_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en |-> (per_clk_en && osc_en));

endmodule

// File: tb/tb_pwr_mode_ctl.sv
module tb_pwr_mode_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst_pin = 1'b0, req_wr = 1'b0, req_idle = 1'b0, req_pd = 1'b0, irq_pend = 1'b0;
    logic cpu_clk_en, per_clk_en, osc_en, wake_pulse, sys_reset, ram_retain;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwr_mode_ctl dut (
        .clk(clk), .rst(rst), .rst_pin(rst_pin), .req_wr(req_wr),
        .req_idle(req_idle), .req_pd(req_pd), .irq_pend(irq_pend),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
        .wake_pulse(wake_pulse), .sys_reset(sys_reset), .ram_retain(ram_retain)
    );

    // vector: {rst_pin, wr, idle, pd, irq, exp cpu, exp per, exp osc}
    localparam logic [7:0] VEC [NV] = '{
        8'b0_1_1_1_0_000, // R3 both bits set: deep sleep wins
        8'b0_0_0_0_1_000, // R5 interrupt ignored in deep sleep
        8'b0_1_1_0_1_000, // R5 writes and irq together ignored
        8'b1_0_0_0_0_001, // R8 pin high restarts oscillator
        8'b0_0_0_0_0_000, // R8 pin low stops it again
        8'b1_0_0_0_1_001, // R8 pin high with irq
        8'b0_0_0_0_0_000  // R5 still in deep sleep
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic p, input logic w, input logic i, input logic d, input logic q);
        rst_pin = p; req_wr = w; req_idle = i; req_pd = d; irq_pend = q;
    endtask

    task automatic hold_pin(input int n);
        rst_pin = 1'b1;
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic wake_and_measure(input string req);
        int n;
        n = 0;
        step();
        irq_pend = 1'b0;
        chk(req, {31'd0, cpu_clk_en}, 32'd0);
        while (!cpu_clk_en && n < 14) begin
            chk(req, {31'd0, wake_pulse}, 32'd0);
            step();
            n++;
        end
        chk(req, (n >= 1 && n <= 12) ? 32'd1 : 32'd0, 32'd1);
        chk(req, {31'd0, wake_pulse}, 32'd1);
        step();
        chk(req, {31'd0, wake_pulse}, 32'd0);
        chk(req, {31'd0, cpu_clk_en}, 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        step();
        step();
        rst = 1'b0;
        // R1 reset state
        chk("R1", {26'd0, cpu_clk_en, per_clk_en, osc_en, wake_pulse, sys_reset, ram_retain},
            32'b111000);
        step();

        // R5 irq in running state gives no wake strobe
        drive(0, 0, 0, 0, 1);
        step();
        chk("R5", {30'd0, wake_pulse, cpu_clk_en}, 32'b01);
        drive(0, 0, 0, 0, 0);

        // R2 enter light sleep
        drive(0, 1, 1, 0, 0);
        step();
        drive(0, 0, 0, 0, 0);
        chk("R2", {29'd0, cpu_clk_en, per_clk_en, osc_en}, 32'b011);
        chk("R10", {31'd0, ram_retain}, 32'd0);
        // R9 write in light sleep ignored
        drive(0, 1, 0, 1, 0);
        step();
        drive(0, 0, 0, 0, 0);
        chk("R9", {29'd0, cpu_clk_en, per_clk_en, osc_en}, 32'b011);

        // R4 wake from light sleep
        irq_pend = 1'b1;
        wake_and_measure("R4");

        // R9 wake and deep-sleep write in the same clock
        drive(0, 1, 1, 0, 0);
        step();
        drive(0, 1, 0, 1, 1);
        step();
        drive(0, 0, 0, 0, 0);
        chk("R9", {30'd0, per_clk_en, osc_en}, 32'b11);
        for (int k = 0; k < 14 && !cpu_clk_en; k++) step();
        chk("R9", {31'd0, cpu_clk_en}, 32'd1);
        step();

        // vector table from the running state
        foreach (VEC[v]) begin
            drive(VEC[v][7], VEC[v][6], VEC[v][5], VEC[v][4], VEC[v][3]);
            step();
            chk($sformatf("R3/R5/R8 vec%0d", v), {29'd0, cpu_clk_en, per_clk_en, osc_en},
                {29'd0, VEC[v][2:0]});
        end
        drive(0, 0, 0, 0, 0);
        chk("R10", {31'd0, ram_retain}, 32'd1);

        // R6 23 highs then a low never qualify
        rst_pin = 1'b1;
        for (int k = 0; k < 23; k++) begin
            step();
            chk("R6", {31'd0, sys_reset}, 32'd0);
        end
        rst_pin = 1'b0;
        step();
        chk("R6", {31'd0, sys_reset}, 32'd0);
        chk("R5", {29'd0, cpu_clk_en, per_clk_en, osc_en}, 32'b000);

        // R6 24 highs qualify; R7 exit deep sleep
        hold_pin(24);
        chk("R6", {31'd0, sys_reset}, 32'd1);
        chk("R10", {31'd0, ram_retain}, 32'd1);
        step();
        chk("R6", {31'd0, sys_reset}, 32'd1);
        rst_pin = 1'b0;
        step();
        chk("R7", {29'd0, cpu_clk_en, per_clk_en, osc_en}, 32'b111);
        chk("R6", {31'd0, sys_reset}, 32'd0);

        // R7 exit light sleep through reset
        drive(0, 1, 1, 0, 0);
        step();
        drive(0, 0, 0, 0, 0);
        chk("R2", {31'd0, cpu_clk_en}, 32'd0);
        hold_pin(24);
        rst_pin = 1'b0;
        step();
        chk("R7", {31'd0, cpu_clk_en}, 32'd1);
        chk("R10", {31'd0, ram_retain}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule